// File: doc/BRIEF.md
# Paged Address Translator with Protection Faults

This block translates one virtual address per request through a set-associative translation buffer. It keeps two buffers, one for instruction fetch and one for data. Each has a parameterised number of ways and sets (default 4 ways by 16 sets). The virtual page is address bits [31:13]. Its low bits pick the set, and every way of that set is compared at the same time. An entry hits when its page number matches and it is either global or tagged with the current process ID. A hit is then checked against the protection rules. Each rule can be switched on or off by its own enable bit.

The lookup is combinational. It returns the page frame, the read, write and execute grants, a fault flag and an exception vector number. The vector base is 4 for the instruction buffer and 8 for the data buffer. When a request faults, two registers are loaded on the next clock edge. The select register records where a refill should go. The cause register records what failed. A 16-bit LFSR advances on every such fault and supplies the refill way on a miss. A debug request performs the lookup but updates none of these registers. Software or a walker loads entries through a simple write port.

Top module: `tlb_xlate_unit`

## Requirements
- R1: Entries are loaded through the write port into the way and set given. wr_itlb_i=1 selects the instruction buffer and 0 the data buffer. The high word holds the page number in [31:13] and the process ID in [7:0]. The low word holds the frame in [31:13], global in bit 4, valid in bit 3, kernel in bit 2, write in bit 1 and execute in bit 0.
- R2: An entry hits when its page number equals vaddr_i[31:13] and either its global bit is set or its process ID equals pid_i. Otherwise the lookup is a miss.
- R3: When several ways hit, the lowest-numbered way wins. pfn_o shows the winning entry's frame, and shows 0 on a miss.
- R4: acc_type_i encodes 0 as read, 1 as write and 2 as execute. Execute uses the instruction buffer with base vector 4. Read and write use the data buffer with base vector 8. A miss sets fault_o and gives the base vector itself.
- R5: On a hit, the faults are tested in this priority order:
  - kernel entry accessed by a user request gives base+2;
  - a write to an entry whose write bit is clear gives base+3;
  - an execute of an entry whose execute bit is clear gives base+3;
  - an entry whose valid bit is clear gives base+1.
- R6: A hit with no fault grants read. Write follows the entry write bit. Execute is granted only in the instruction buffer, and only when the execute check is off or the entry execute bit is set. A fault clears all three grants.
- R7: prot_en_i bit 0 enables the valid check, bit 1 the execute check, bit 2 the kernel check and bit 3 the write check. A check whose bit is clear never faults.
- R8: The LFSR resets to 0xCCCC. On every non-debug faulting request it shifts right by one, and the new bit 15 is the parity of (state AND 0x8805). A miss takes its refill way from the LFSR's low 2 bits as they were before that step.
- R9: After a non-debug faulting request, sel_o holds the set index in [3:0] and the way in [5:4]. The way is the refill way on a miss and the hitting way on a protection fault.
- R10: After a non-debug faulting request, cause_o holds pid_i in [7:0], the access code (read 0, write 1, execute 2) in [9:8] and the virtual page in [31:13]. All other bits are zero.
- R11: A request with debug_i set still returns the full lookup result. It leaves sel_o, cause_o and the LFSR unchanged.
- R12: After reset, sel_o and cause_o are zero and every buffer entry is cleared. Requests that do not fault change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request present |
| vaddr_i | input | 32 | Virtual address |
| acc_type_i | input | 2 | 0 read, 1 write, 2 execute |
| user_i | input | 1 | Request made in user mode |
| pid_i | input | 8 | Current process ID |
| prot_en_i | input | 4 | Check enables: valid, execute, kernel, write (bit 0 up) |
| debug_i | input | 1 | Lookup without register side effects |
| wr_en_i | input | 1 | Entry write strobe |
| wr_itlb_i | input | 1 | 1 writes instruction buffer, 0 data buffer |
| wr_way_i | input | 2 | Way to write |
| wr_idx_i | input | 4 | Set to write |
| wr_hi_i | input | 32 | Entry high word |
| wr_lo_i | input | 32 | Entry low word |
| pfn_o | output | 19 | Physical frame number |
| perm_r_o | output | 1 | Read granted |
| perm_w_o | output | 1 | Write granted |
| perm_x_o | output | 1 | Execute granted |
| fault_o | output | 1 | Miss or protection fault |
| vec_o | output | 4 | Exception vector number |
| sel_o | output | 6 | Refill select register |
| cause_o | output | 32 | Fault cause register |

## Verification
The refill way on a miss is the hardest result to reach from the ports. It depends on how many non-debug faults came earlier, in their exact order, including the protection faults. The bench therefore carries its own LFSR model and steps it on every non-debug fault it causes. It reads the expected way from the model before each step. Debug misses are placed between real misses to show that the sequence does not move. Two ways of one set are loaded with the same page to exercise the lowest-way priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 13;
  localparam int VPN_W  = VA_W - PG_LSB;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2} acc_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [4:0]       rsvd;
    logic [7:0]       pid;
  } tlb_hi_t;

  typedef struct packed {
    logic [VPN_W-1:0] pfn;
    logic [7:0]       rsvd;
    logic             g;
    logic             v;
    logic             k;
    logic             w;
    logic             x;
  } tlb_lo_t;

  typedef struct packed {
    logic en_w;
    logic en_k;
    logic en_x;
    logic en_v;
  } prot_en_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [WAY_W-1:0]       wr_way_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [31:0]            wr_hi_i,
  input  logic [31:0]            wr_lo_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic [WAYS-1:0][31:0]  rd_hi_o,
  output logic [WAYS-1:0][31:0]  rd_lo_o
);
  logic [31:0] hi_q [WAYS][SETS];
  logic [31:0] lo_q [WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          hi_q[w][s] <= '0;
          lo_q[w][s] <= '0;
        end
    end else if (wr_en_i) begin
      hi_q[wr_way_i][wr_idx_i] <= wr_hi_i;
      lo_q[wr_way_i][wr_idx_i] <= wr_lo_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_hi_o[w] = hi_q[w][rd_idx_i];
    assign rd_lo_o[w] = lo_q[w][rd_idx_i];
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][31:0] hi_i,
  input  logic [WAYS-1:0][31:0] lo_i,
  input  logic [VPN_W-1:0]      vpn_i,
  input  logic [7:0]            pid_i,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      way_o,
  output tlb_lo_t               ent_o
);
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    tlb_hi_t h;
    tlb_lo_t l;
    assign h = tlb_hi_t'(hi_i[w]);
    assign l = tlb_lo_t'(lo_i[w]);
    assign way_hit[w] = (h.vpn == vpn_i) && (l.g || (h.pid == pid_i));
  end

  // lowest way wins
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    ent_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
        ent_o = tlb_lo_t'(lo_i[w]);
      end
    end
  end
endmodule

// File: rtl/tlb_prot_check.sv
module tlb_prot_check import tlb_pkg::*; (
  input  logic       hit_i,
  input  tlb_lo_t    ent_i,
  input  logic       is_wr_i,
  input  logic       is_ex_i,
  input  logic       user_i,
  input  prot_en_t   en_i,
  output logic       fault_o,
  output logic [3:0] vec_o,
  output logic       perm_r_o,
  output logic       perm_w_o,
  output logic       perm_x_o
);
  logic [3:0] base;
  assign base = is_ex_i ? 4'd4 : 4'd8;

  always_comb begin
    fault_o = 1'b1;
    vec_o   = base;
    if (hit_i) begin
      if (en_i.en_k && ent_i.k && user_i)        vec_o = base + 4'd2;
      else if (is_wr_i && en_i.en_w && !ent_i.w) vec_o = base + 4'd3;
      else if (is_ex_i && en_i.en_x && !ent_i.x) vec_o = base + 4'd3;
      else if (en_i.en_v && !ent_i.v)            vec_o = base + 4'd1;
      else                                       fault_o = 1'b0;
    end
    perm_r_o = !fault_o;
    perm_w_o = !fault_o && ent_i.w;
    perm_x_o = !fault_o && is_ex_i && (!en_i.en_x || ent_i.x);
  end
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter logic [15:0] SEED = 16'hCCCC,
  parameter logic [15:0] TAPS = 16'h8805
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  output logic [15:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= SEED;
    else if (step_i) state_o <= {^(state_o & TAPS), state_o[15:1]};
  end
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit import tlb_pkg::*; #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEL_W = IDX_W + WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       vaddr_i,
  input  logic [1:0]        acc_type_i,
  input  logic              user_i,
  input  logic [7:0]        pid_i,
  input  logic [3:0]        prot_en_i,
  input  logic              debug_i,
  input  logic              wr_en_i,
  input  logic              wr_itlb_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_hi_i,
  input  logic [31:0]       wr_lo_i,
  output logic [VPN_W-1:0]  pfn_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic              fault_o,
  output logic [3:0]        vec_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [31:0]       cause_o
);
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic             is_ex, is_wr;
  logic [1:0]       acc_code;

  assign vpn      = vaddr_i[VA_W-1:PG_LSB];
  assign idx      = vpn[IDX_W-1:0];
  assign is_ex    = acc_type_i == ACC_EX;
  assign is_wr    = acc_type_i == ACC_WR;
  assign acc_code = is_ex ? 2'd2 : (is_wr ? 2'd1 : 2'd0);

  // buffer 0 = instruction, 1 = data
  logic [1:0][WAYS-1:0][31:0] rd_hi, rd_lo;
  for (genvar t = 0; t < 2; t++) begin : g_buf
    tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i && (wr_itlb_i == (t == 0))),
      .wr_way_i (wr_way_i),
      .wr_idx_i (wr_idx_i),
      .wr_hi_i  (wr_hi_i),
      .wr_lo_i  (wr_lo_i),
      .rd_idx_i (idx),
      .rd_hi_o  (rd_hi[t]),
      .rd_lo_o  (rd_lo[t])
    );
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  tlb_lo_t          ent;

  tlb_match #(.WAYS(WAYS)) u_match (
    .hi_i  (is_ex ? rd_hi[0] : rd_hi[1]),
    .lo_i  (is_ex ? rd_lo[0] : rd_lo[1]),
    .vpn_i (vpn),
    .pid_i (pid_i),
    .hit_o (hit),
    .way_o (hit_way),
    .ent_o (ent)
  );

  tlb_prot_check u_prot (
    .hit_i    (hit),
    .ent_i    (ent),
    .is_wr_i  (is_wr),
    .is_ex_i  (is_ex),
    .user_i   (user_i),
    .en_i     (prot_en_t'(prot_en_i)),
    .fault_o  (fault_o),
    .vec_o    (vec_o),
    .perm_r_o (perm_r_o),
    .perm_w_o (perm_w_o),
    .perm_x_o (perm_x_o)
  );

  assign pfn_o = hit ? ent.pfn : '0;

  logic        upd;
  logic [15:0] lfsr;
  assign upd = req_valid_i && fault_o && !debug_i;

  tlb_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (upd),
    .state_o (lfsr)
  );

  logic [WAY_W-1:0] fault_way;
  assign fault_way = hit ? hit_way : lfsr[WAY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      cause_o <= '0;
    end else if (upd) begin
      sel_o   <= {fault_way, idx};
      cause_o <= {vpn, 3'b000, acc_code, pid_i};
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int SETS = 16,
  parameter int SEL_W = 6,
  localparam int IDX_W = $clog2(SETS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [31:0]      vaddr_i,
  input logic [1:0]       acc_type_i,
  input logic [7:0]       pid_i,
  input logic             debug_i,
  input logic             perm_r_o,
  input logic             perm_w_o,
  input logic             perm_x_o,
  input logic             fault_o,
  input logic [3:0]       vec_o,
  input logic [SEL_W-1:0] sel_o,
  input logic [31:0]      cause_o
);
  // R11
  hold_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && fault_o && !debug_i) |=> ($stable(sel_o) && $stable(cause_o)));

  // R9
  sel_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fault_o && !debug_i) |=> sel_o[IDX_W-1:0] == $past(vaddr_i[13 +: IDX_W]));

  // R10
  cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fault_o && !debug_i) |=>
      (cause_o[31:13] == $past(vaddr_i[31:13]) && cause_o[7:0] == $past(pid_i)));

  // R6
  fault_noperm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(perm_r_o || perm_w_o || perm_x_o));

  // R6
  exec_only_itlb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_x_o |-> acc_type_i == 2'd2);

  // R4
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (vec_o[3:2] == ((acc_type_i == 2'd2) ? 2'b01 : 2'b10)));
endmodule

bind tlb_xlate_unit tlb_xlate_chk #(.SETS(SETS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_tlb_xlate_unit.sv
`timescale 1ns/1ps
module tb_tlb_xlate_unit;
  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, user_i = 0, debug_i = 0;
  logic [31:0] vaddr_i = 0;
  logic [1:0]  acc_type_i = 0;
  logic [7:0]  pid_i = 0;
  logic [3:0]  prot_en_i = 4'hF;
  logic        wr_en_i = 0, wr_itlb_i = 0;
  logic [1:0]  wr_way_i = 0;
  logic [3:0]  wr_idx_i = 0;
  logic [31:0] wr_hi_i = 0, wr_lo_i = 0;
  logic [18:0] pfn_o;
  logic        perm_r_o, perm_w_o, perm_x_o, fault_o;
  logic [3:0]  vec_o;
  logic [5:0]  sel_o;
  logic [31:0] cause_o;

  tlb_xlate_unit dut (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  logic [15:0] m_lfsr = 16'hCCCC;
  logic        s_f, s_r, s_w, s_x;
  logic [3:0]  s_vec;
  logic [18:0] s_pfn;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic load(input bit itlb, input [1:0] way, input [18:0] vpn, input [7:0] pid,
                      input [18:0] pfn, input [4:0] gvkwx);
    @(negedge clk_i);
    wr_en_i = 1; wr_itlb_i = itlb; wr_way_i = way; wr_idx_i = vpn[3:0];
    wr_hi_i = {vpn, 5'b0, pid}; wr_lo_i = {pfn, 8'b0, gvkwx};
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic access(input [1:0] acc, input bit usr, input [7:0] pid, input [31:0] va, input bit dbg);
    @(negedge clk_i);
    req_valid_i = 1; acc_type_i = acc; user_i = usr; pid_i = pid; vaddr_i = va; debug_i = dbg;
    #2;
    s_f = fault_o; s_r = perm_r_o; s_w = perm_w_o; s_x = perm_x_o; s_vec = vec_o; s_pfn = pfn_o;
    @(negedge clk_i);
    req_valid_i = 0; debug_i = 0;
  endtask

  // checks the registers after a non-debug fault and steps the model LFSR
  task automatic expect_regs(input string r, input bit miss, input [1:0] hway,
                             input [1:0] code, input [7:0] pid, input [31:0] va);
    logic [1:0] way;
    way = miss ? m_lfsr[1:0] : hway;
    chk(sel_o == {way, va[16:13]}, r, {26'b0, sel_o}, {26'b0, way, va[16:13]});
    chk(cause_o == {va[31:13], 3'b0, code, pid}, r, cause_o, {va[31:13], 3'b0, code, pid});
    m_lfsr = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
  endtask

  task automatic t_reset;
    chk(sel_o == 0, "R12 sel", {26'b0, sel_o}, 0);
    chk(cause_o == 0, "R12 cause", cause_o, 0);
    access(2'd0, 0, 8'd5, 32'h0000_2000, 0);
    chk(s_f && s_vec == 8, "R12 cleared entries miss", {s_f, s_vec}, {1'b1, 4'd8});
    expect_regs("R8 first way", 1, 0, 2'd0, 8'd5, 32'h0000_2000);
  endtask

  task automatic t_hit_pid;
    access(2'd0, 1, 8'd5, 32'h0000_2004, 0);
    chk(!s_f && s_pfn == 19'h12345, "R2 R3 pid hit pfn", {s_f, s_pfn}, {1'b0, 19'h12345});
    chk(s_r && s_w && !s_x, "R6 read perms", {s_r, s_w, s_x}, 3'b110);
    access(2'd1, 1, 8'd5, 32'h0000_2000, 0);
    chk(!s_f && s_w, "R6 write hit", {s_f, s_w}, 2'b01);
    chk(sel_o == {2'd0, 4'd1}, "R12 no update on hit", {26'b0, sel_o}, 32'h1);
  endtask

  task automatic t_pid_miss;
    access(2'd0, 0, 8'd6, 32'h0000_2000, 0);
    chk(s_f && s_vec == 8 && s_pfn == 0, "R2 pid mismatch miss", {s_f, s_vec, s_pfn}, {1'b1, 4'd8, 19'd0});
    expect_regs("R8 R9 R10 miss regs", 1, 0, 2'd0, 8'd6, 32'h0000_2000);
  endtask

  task automatic t_global_kernel;
    access(2'd0, 0, 8'd9, 32'h0002_4000, 0);
    chk(!s_f && s_pfn == 19'h00abc && s_r && !s_w, "R2 global hit", {s_f, s_pfn, s_r, s_w}, {1'b0, 19'h00abc, 2'b10});
    access(2'd0, 1, 8'd9, 32'h0002_4000, 0);
    chk(s_f && s_vec == 10, "R5 kernel fault", {s_f, s_vec}, {1'b1, 4'd10});
    expect_regs("R9 hit way in sel", 0, 2, 2'd0, 8'd9, 32'h0002_4000);
    access(2'd1, 0, 8'd9, 32'h0002_4000, 0);
    chk(s_f && s_vec == 11, "R5 write fault", {s_f, s_vec}, {1'b1, 4'd11});
    expect_regs("R10 write code", 0, 2, 2'd1, 8'd9, 32'h0002_4000);
    access(2'd1, 1, 8'd9, 32'h0002_4000, 0);
    chk(s_f && s_vec == 10, "R5 kernel beats write", {s_f, s_vec}, {1'b1, 4'd10});
    expect_regs("R5 priority regs", 0, 2, 2'd1, 8'd9, 32'h0002_4000);
    prot_en_i = 4'b0111;
    access(2'd1, 0, 8'd9, 32'h0002_4000, 0);
    chk(!s_f && !s_w && s_r, "R7 write check off", {s_f, s_w, s_r}, 3'b001);
    prot_en_i = 4'b1011;
    access(2'd0, 1, 8'd9, 32'h0002_4000, 0);
    chk(!s_f, "R7 kernel check off", {31'b0, s_f}, 0);
    prot_en_i = 4'hF;
  endtask

  task automatic t_exec;
    access(2'd2, 0, 8'd5, 32'h0000_8000, 0);
    chk(s_f && s_vec == 7, "R5 exec fault", {s_f, s_vec}, {1'b1, 4'd7});
    expect_regs("R10 exec code", 0, 0, 2'd2, 8'd5, 32'h0000_8000);
    prot_en_i = 4'b1101;
    access(2'd2, 0, 8'd5, 32'h0000_8000, 0);
    chk(!s_f && s_x, "R7 exec check off", {s_f, s_x}, 2'b01);
    prot_en_i = 4'hF;
    access(2'd2, 0, 8'd5, 32'h0000_A000, 0);
    chk(!s_f && s_x && s_pfn == 19'h00555, "R6 exec grant", {s_f, s_x, s_pfn}, {2'b01, 19'h00555});
    access(2'd0, 0, 8'd5, 32'h0000_A000, 0);
    chk(s_f && s_vec == 8, "R4 data buffer separate", {s_f, s_vec}, {1'b1, 4'd8});
    expect_regs("R4 data miss regs", 1, 0, 2'd0, 8'd5, 32'h0000_A000);
    access(2'd2, 0, 8'd5, 32'h0000_2000, 0);
    chk(s_f && s_vec == 4, "R4 instr miss vector", {s_f, s_vec}, {1'b1, 4'd4});
    expect_regs("R8 instr miss regs", 1, 0, 2'd2, 8'd5, 32'h0000_2000);
  endtask

  task automatic t_valid_lowest;
    access(2'd0, 0, 8'd5, 32'h0000_C000, 0);
    chk(s_f && s_vec == 9, "R5 invalid fault", {s_f, s_vec}, {1'b1, 4'd9});
    expect_regs("R9 invalid regs", 0, 0, 2'd0, 8'd5, 32'h0000_C000);
    prot_en_i = 4'b1110;
    access(2'd0, 0, 8'd5, 32'h0000_C000, 0);
    chk(!s_f && s_r, "R7 valid check off", {s_f, s_r}, 2'b01);
    prot_en_i = 4'hF;
    access(2'd0, 0, 8'd5, 32'h0000_6000, 0);
    chk(!s_f && s_pfn == 19'h00111, "R3 lowest way wins", {s_f, s_pfn}, {1'b0, 19'h00111});
  endtask

  task automatic t_debug;
    logic [5:0]  sv_sel;
    logic [31:0] sv_cause;
    sv_sel = sel_o; sv_cause = cause_o;
    access(2'd1, 0, 8'd77, 32'h1234_E000, 1);
    chk(s_f && s_vec == 8, "R11 debug lookup", {s_f, s_vec}, {1'b1, 4'd8});
    chk(sel_o == sv_sel && cause_o == sv_cause, "R11 regs held", cause_o, sv_cause);
    access(2'd0, 0, 8'd77, 32'h1234_E000, 1);
    for (int i = 0; i < 5; i++) begin
      access(2'd0, 0, 8'd3, 32'h4000_0000 + (i << 13), 0);
      expect_regs("R8 R11 lfsr sequence", 1, 0, 2'd0, 8'd3, 32'h4000_0000 + (i << 13));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    // R1 loads
    load(0, 2'd0, 19'h00001, 8'd5, 19'h12345, 5'b01011);
    load(0, 2'd2, 19'h00012, 8'd0, 19'h00abc, 5'b11100);
    load(0, 2'd1, 19'h00022, 8'd0, 19'h00def, 5'b11011);
    load(0, 2'd1, 19'h00003, 8'd5, 19'h00111, 5'b01010);
    load(0, 2'd3, 19'h00003, 8'd5, 19'h00222, 5'b01010);
    load(0, 2'd0, 19'h00006, 8'd5, 19'h00666, 5'b00010);
    load(1, 2'd0, 19'h00004, 8'd5, 19'h00444, 5'b01000);
    load(1, 2'd1, 19'h00005, 8'd5, 19'h00555, 5'b01001);
    t_hit_pid();
    t_pid_miss();
    t_global_kernel();
    t_exec();
    t_valid_lowest();
    t_debug();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule